// File: doc/BRIEF.md
# Instruction Fetch Target Router

This block decides, for every instruction fetch, which memory serves it: the tightly coupled instruction RAM, the instruction cache, or level-two memory. It checks the fetch address against a programmable instruction RAM window (base address plus a power-of-two size). It also takes the instruction cache lookup result together with the page attributes: cacheable, shareable, and the global cache enable.

The decision comes out as a registered one-hot target select one clock after the fetch is presented. A separate strobe asks for a cache linefill when the fetch goes to level-two memory on a cacheable page with the cache turned on. The fetch side never decodes the data RAM window. A fetch whose address lies in that window is treated like any other address outside the instruction RAM and cache, so it is routed to main memory. The RAM and cache arrays sit outside this block.

Top module: `ifetch_router`

## Requirements
- R1: A valid fetch whose address lies inside the instruction RAM window selects the instruction RAM (target bit 0), whatever the cache hit and attribute inputs are.
- R2: A fetch routed to the instruction RAM never raises the linefill strobe, even on a cacheable page with the cache enabled.
- R3: A cache hit is credited (target bit 1) only when the page is cacheable and not shareable; otherwise the hit input is treated as a miss.
- R4: A fetch that misses the instruction RAM and has no credited cache hit selects level-two memory (target bit 2) and raises the linefill strobe when the page is cacheable and the cache is enabled.
- R5: Such a fetch on a non-cacheable page, or with the cache disabled, selects level-two memory with the linefill strobe low.
- R6: The data RAM window indication has no effect on the target select or the linefill strobe.
- R7: The target select and linefill strobe are registered. They reflect the fetch presented on the previous rising clock edge, with at most one target bit set. When no fetch was presented, all target bits and the strobe are zero.
- R8: An address lies in the instruction RAM window when all its bits at positions from the size exponent upwards equal the same bits of the base. An exponent of 0 matches only the exact base; an exponent equal to the address width matches every address.
- R9: While reset is asserted (active low), the target select and linefill strobe are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_addr | input | AW | Fetch byte address |
| itcm_base | input | AW | Base of the instruction RAM window |
| itcm_size_log2 | input | SZW | Window size exponent in bytes, 0 to AW |
| dtcm_range_hit | input | 1 | Address lies in the data RAM window; ignored by routing |
| page_cacheable | input | 1 | Page attribute: cacheable |
| page_shareable | input | 1 | Page attribute: shareable |
| icache_enable | input | 1 | Instruction cache globally enabled |
| icache_hit | input | 1 | Raw instruction cache tag hit |
| target_sel | output | 3 | One-hot target: bit 0 instruction RAM, bit 1 cache, bit 2 level two |
| linefill_req | output | 1 | Request an instruction cache linefill for this fetch |

## Verification
The assertions assume that all fetch inputs are held at zero while reset is asserted. This lets the one-cycle-back checks look at a defined previous value on the first edge after reset. They also assume that the size exponent never exceeds the address width. The stimulus drives every input only on the falling edge. It keeps the exponent inside 0 to AW and leaves inputs at zero during reset. Every combination of window hit, cache hit, cacheable, shareable, enable and data-window flag is applied with the window fixed. Window edges and the two extreme exponents are then exercised separately.

// File: rtl/ifr_pkg.sv
package ifr_pkg;

    typedef enum logic [2:0] {
        TGT_NONE   = 3'b000,
        TGT_ITCM   = 3'b001,
        TGT_ICACHE = 3'b010,
        TGT_L2     = 3'b100
    } target_e;

    typedef struct packed {
        target_e sel;
        logic    fill;
    } route_t;

endpackage

// File: rtl/ifr_range_match.sv
module ifr_range_match #(
    parameter int unsigned AW  = 32,
    parameter int unsigned SZW = $clog2(AW + 1)
) (
    input  logic [AW-1:0]  addr,
    input  logic [AW-1:0]  base,
    input  logic [SZW-1:0] size_log2,
    output logic           in_range
);

    localparam int unsigned PADW = 32 - SZW;

    logic [31:0]   size_ext;
    logic [AW-1:0] keep;
    logic [AW-1:0] agree;

    assign size_ext = {{PADW{1'b0}}, size_log2};

    // Bits at or above the size exponent take part in the compare.
    for (genvar i = 0; i < AW; i++) begin : g_mask
        localparam int unsigned IDX = i;
        assign keep[i]  = (size_ext <= IDX);
        assign agree[i] = ~(addr[i] ^ base[i]) | ~keep[i];
    end

    assign in_range = &agree;

endmodule

// File: rtl/ifr_hit_qualify.sv
module ifr_hit_qualify (
    input  logic raw_hit,
    input  logic cacheable,
    input  logic shareable,
    output logic credited_hit
);

    // A tag hit only counts on pages the cache may legally hold.
    assign credited_hit = raw_hit & cacheable & ~shareable;

endmodule

// File: rtl/ifetch_router.sv
module ifetch_router
    import ifr_pkg::*;
#(
    parameter int unsigned AW  = 32,
    parameter int unsigned SZW = $clog2(AW + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fetch_valid,
    input  logic [AW-1:0]  fetch_addr,
    input  logic [AW-1:0]  itcm_base,
    input  logic [SZW-1:0] itcm_size_log2,
    input  logic           dtcm_range_hit,
    input  logic           page_cacheable,
    input  logic           page_shareable,
    input  logic           icache_enable,
    input  logic           icache_hit,
    output logic [2:0]     target_sel,
    output logic           linefill_req
);

    logic   itcm_in_range;
    logic   ic_credited;
    route_t route_d;
    route_t route_q;

    // The fetch side deliberately does not decode the data RAM window.
    logic   unused_dtcm_flag;
    assign  unused_dtcm_flag = dtcm_range_hit;

    ifr_range_match #(
        .AW  (AW),
        .SZW (SZW)
    ) u_itcm_match (
        .addr      (fetch_addr),
        .base      (itcm_base),
        .size_log2 (itcm_size_log2),
        .in_range  (itcm_in_range)
    );

    ifr_hit_qualify u_hit_qual (
        .raw_hit      (icache_hit),
        .cacheable    (page_cacheable),
        .shareable    (page_shareable),
        .credited_hit (ic_credited)
    );

    // Priority: instruction RAM, then credited cache hit, then level two.
    always_comb begin
        route_d      = '0;
        route_d.sel  = TGT_NONE;
        route_d.fill = 1'b0;
        if (fetch_valid) begin
            if (itcm_in_range) begin
                route_d.sel = TGT_ITCM;
            end else if (ic_credited) begin
                route_d.sel = TGT_ICACHE;
            end else begin
                route_d.sel  = TGT_L2;
                route_d.fill = page_cacheable & icache_enable;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q <= '0;
        end else begin
            route_q <= route_d;
        end
    end

    assign target_sel   = route_q.sel;
    assign linefill_req = route_q.fill;

    // R1: a window hit wins over everything else.
    a_r1_itcm_priority: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fetch_valid && itcm_in_range) |-> (target_sel == TGT_ITCM));

    // R2: the instruction RAM path never fills the cache.
    a_r2_no_fill_on_itcm: assert property (@(posedge clk) disable iff (!rst_n)
        (target_sel == TGT_ITCM) |-> !linefill_req);

    // R3: cache selected only for cacheable, non-shareable pages.
    a_r3_cache_attr: assert property (@(posedge clk) disable iff (!rst_n)
        (target_sel == TGT_ICACHE) |-> $past(page_cacheable && !page_shareable && icache_hit));

    // R4: a fill goes with level two and needs cacheable plus enable.
    a_r4_fill_cond: assert property (@(posedge clk) disable iff (!rst_n)
        linefill_req |-> (target_sel == TGT_L2) && $past(page_cacheable && icache_enable));

    // R5: cache disabled means no fill.
    a_r5_no_fill_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!icache_enable) |-> !linefill_req);

    // R7: at most one target, and nothing without a fetch.
    a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(target_sel));

    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!fetch_valid) |-> (target_sel == TGT_NONE) && !linefill_req);

    // R9: outputs cleared while in reset.
    always_comb begin
        if (!rst_n) begin
            a_r9_reset_clear: assert (route_q == '0);
        end
    end

endmodule

// File: tb/tb_ifetch_router.sv
module tb_ifetch_router;

    localparam int unsigned AW  = 32;
    localparam int unsigned SZW = $clog2(AW + 1);

    logic           clk = 1'b0;
    logic           rst_n;
    logic           fetch_valid;
    logic [AW-1:0]  fetch_addr;
    logic [AW-1:0]  itcm_base;
    logic [SZW-1:0] itcm_size_log2;
    logic           dtcm_range_hit;
    logic           page_cacheable;
    logic           page_shareable;
    logic           icache_enable;
    logic           icache_hit;
    logic [2:0]     target_sel;
    logic           linefill_req;

    always #10 clk = ~clk;   // 50 MHz

    ifetch_router #(.AW(AW), .SZW(SZW)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_valid    (fetch_valid),
        .fetch_addr     (fetch_addr),
        .itcm_base      (itcm_base),
        .itcm_size_log2 (itcm_size_log2),
        .dtcm_range_hit (dtcm_range_hit),
        .page_cacheable (page_cacheable),
        .page_shareable (page_shareable),
        .icache_enable  (icache_enable),
        .icache_hit     (icache_hit),
        .target_sel     (target_sel),
        .linefill_req   (linefill_req)
    );

    typedef struct {
        logic [2:0] sel;
        logic       fill;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    task automatic check(input string tag, input logic [2:0] got_sel, input logic got_fill,
                         input logic [2:0] exp_sel, input logic exp_fill);
        n_checks++;
        if (got_sel !== exp_sel || got_fill !== exp_fill) begin
            n_fail++;
            $display("FAIL %s: got sel=%b fill=%b, expected sel=%b fill=%b",
                     tag, got_sel, got_fill, exp_sel, exp_fill);
        end
    endtask

    // Reference model written from the requirements.
    task automatic drive(input logic v, input logic [AW-1:0] a, input logic [AW-1:0] b,
                         input logic [SZW-1:0] sz, input logic d, input logic c,
                         input logic s, input logic en, input logic h, input string note);
        exp_t       e;
        logic [AW:0] a_x;
        logic [AW:0] b_x;
        logic       win;
        @(negedge clk);
        fetch_valid    = v;
        fetch_addr     = a;
        itcm_base      = b;
        itcm_size_log2 = sz;
        dtcm_range_hit = d;
        page_cacheable = c;
        page_shareable = s;
        icache_enable  = en;
        icache_hit     = h;
        a_x = {1'b0, a} >> sz;   // R8: compare bits from the exponent upwards
        b_x = {1'b0, b} >> sz;
        win = (a_x == b_x);
        e.fill = 1'b0;
        if (!v) begin
            e.sel = 3'b000; e.tag = {"R7 idle ", note};
        end else if (win) begin
            e.sel = 3'b001; e.tag = {"R1/R2/R8 ", note};
        end else if (h && c && !s) begin
            e.sel = 3'b010; e.tag = {"R3 ", note};
        end else begin
            e.sel  = 3'b100;
            e.fill = c && en;
            e.tag  = e.fill ? {"R4 ", note} : {"R5 ", note};
        end
        exp_q.push_back(e);
    endtask

    // Monitor: one item per edge, read just after the register updates.
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, target_sel, linefill_req, e.sel, e.fill);
        end
    end

    localparam logic [AW-1:0] BASE = 32'h0010_0000;

    initial begin
        rst_n = 1'b0;
        fetch_valid = 0; fetch_addr = '0; itcm_base = '0; itcm_size_log2 = '0;
        dtcm_range_hit = 0; page_cacheable = 0; page_shareable = 0;
        icache_enable = 0; icache_hit = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset", target_sel, linefill_req, 3'b000, 1'b0);
        rst_n = 1'b1;

        // Exhaustive sweep: window, cache hit, attributes, data-window flag (R6).
        for (int k = 0; k < 64; k++) begin
            logic [AW-1:0] adr;
            adr = k[5] ? 32'h0010_1234 : 32'h0020_0040;
            drive(1'b1, adr, BASE, 6'd16, k[0], k[1], k[2], k[3], k[4], "sweep");
        end

        // R6: same fetch, data-window flag toggled, outputs must match.
        drive(1'b1, 32'h0020_0080, BASE, 6'd16, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R6 dtcm off");
        drive(1'b1, 32'h0020_0080, BASE, 6'd16, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R6 dtcm on");
        drive(1'b1, 32'h0020_0080, BASE, 6'd16, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R6 dtcm on hit");

        // R8 window edges.
        drive(1'b1, 32'h0010_FFFC, BASE, 6'd16, 0, 1, 0, 1, 1, "R8 top inside");
        drive(1'b1, 32'h0011_0000, BASE, 6'd16, 0, 1, 0, 1, 0, "R8 just above");
        drive(1'b1, 32'h000F_FFFC, BASE, 6'd16, 0, 1, 0, 1, 0, "R8 just below");
        drive(1'b1, BASE,          BASE, 6'd0,  0, 1, 0, 1, 1, "R8 exact");
        drive(1'b1, BASE + 1,      BASE, 6'd0,  0, 1, 0, 1, 0, "R8 exp0 off by one");
        drive(1'b1, 32'hFFFF_FFF0, BASE, 6'd32, 0, 1, 0, 1, 1, "R8 full width");

        // R7: idle gaps between fetches.
        drive(1'b0, BASE, BASE, 6'd16, 0, 1, 0, 1, 1, "gap");
        drive(1'b1, BASE, BASE, 6'd16, 0, 1, 0, 1, 1, "after gap");
        drive(1'b0, '0,   BASE, 6'd16, 0, 0, 0, 0, 0, "gap2");
        drive(1'b0, '0,   BASE, 6'd16, 0, 0, 0, 0, 0, "gap3");

        repeat (3) @(posedge clk);
        #2;
        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R7: %0d results never produced, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R7: watchdog expired, got hang, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule